// File: doc/BRIEF.md
# Dual-Bank Systolic Multiply-Accumulate Filter Array

This block is a 21-stage multiply-accumulate engine built from three sections of seven stages each. Each section is a transposed-form transversal filter. The section's own 8-bit input sample goes to all seven of its stages in the same clock. Each stage adds its product to the registered partial sum of the stage before it.

The sections are chained: a section's final partial sum passes through one extra register and then enters the first stage of the next section. By choosing what reaches the three tap inputs, the caller can use the array as a 21-tap one-dimensional filter or as a three-row by seven-column two-dimensional window. The tap inputs can carry delayed copies of one stream, or three image rows.

Coefficients are double-buffered. Two banks of 21 words exist, and one of them is active at any time. A write port loads words into the inactive bank while data keeps flowing. A control word on the same port selects the active bank, turns automatic per-sample swapping on or off, and picks signed or unsigned interpretation for data and for coefficients independently. Sums are carried exactly and appear as a 22-bit two's-complement value.

Top module: `dual_bank_mac_array`

## Requirements
- R1: After reset the output is 0, bank 0 is active, continuous swapping is off, data and coefficients are unsigned, and every coefficient word in both banks is 0.
- R2: Let x2(t) be the section-2 tap sampled at clock edge t, and let c[j] be the active coefficient at global index j. The output after edge t includes, for each stage i in 0..6, the term x2(t-6+i)·c[14+i].
- R3: Section s (0, 1 or 2) feeds section s+1 through one register. Its stage-i product therefore reaches the output 6-i+8·(2-s) edges after its tap sample. Section s is taps_i bits [8s+7:8s], and its stages use global coefficient indices 7s..7s+6.
- R4: A write with address 0..20 stores wr_data_i in that index of the bank that is inactive in the write cycle. The active coefficients do not change.
- R5: A write to address 31 is the control word: bit 0 selects the active bank, bit 1 enables continuous swapping, bit 2 selects signed data, and bit 3 selects signed coefficients. The new settings take effect from the next clock edge, and each product uses the bank active in its own cycle.
- R6: While continuous swapping is on, the active bank inverts at every clock edge. A control-word write in the same cycle overrides the inversion with the written bit 0.
- R7: With bit 2 clear, tap samples are unsigned 0..255; with it set, they are two's complement -128..127.
- R8: With bit 3 clear, coefficients are unsigned 0..255; with it set, they are two's complement -128..127.
- R9: Products and partial sums are never rounded or truncated. All taps and coefficients at 255 unsigned give 1365525. All at -128 signed give 344064.
- R10: Writes to addresses 21..30 change neither coefficient bank nor any control setting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one sample per section per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| taps_i | input | 24 | Three 8-bit section taps, section s at bits [8s+7:8s] |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 5 | Write address: 0..20 coefficient, 31 control word |
| wr_data_i | input | 8 | Write data |
| sum_o | output | 22 | Two's-complement array sum |

## Verification
Two functions can coincide in one cycle. The continuous-swap inversion and a control-word write can arrive on the same edge, and so can a coefficient write and a bank swap. In the second case, "inactive" has to mean the bank that is inactive during the write cycle, not the one after the swap. The bench turns continuous swapping on and keeps loading coefficients every cycle, so each write lands on a different physical bank. It then issues control writes whose bit 0 either agrees or disagrees with the pending inversion. Every output is compared against a convolution model that records, cycle by cycle, which bank and which formats were in force when each product was formed.

// File: rtl/mac_array_pkg.sv
package mac_array_pkg;

    // Control word layout; bit order matters because it is decoded from wr_data
    typedef struct packed {
        logic coef_signed;   // bit 3
        logic data_signed;   // bit 2
        logic cont_swap;     // bit 1
        logic bank;          // bit 0
    } ctrl_t;

    localparam int CTRL_BITS = $bits(ctrl_t);

endpackage

// File: rtl/mac_coef_store.sv
module mac_coef_store
    import mac_array_pkg::*;
#(
    parameter int NTAP   = 21,
    parameter int COEF_W = 8,
    parameter int ADDR_W = 5
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  logic [ADDR_W-1:0]        wr_addr,
    input  logic [COEF_W-1:0]        wr_data,
    output logic [NTAP*COEF_W-1:0]   coef_o,
    output logic                     data_signed_o,
    output logic                     coef_signed_o
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR = {ADDR_W{1'b1}};

    typedef struct packed {
        logic [1:0][NTAP-1:0][COEF_W-1:0] bank;
        ctrl_t                            ctrl;
    } store_t;

    store_t st_d, st_q;
    logic   hit_ctrl, hit_coef;

    always_comb begin
        st_d     = st_q;
        hit_ctrl = wr_en && (wr_addr == CTRL_ADDR);
        hit_coef = wr_en && (int'(wr_addr) < NTAP);
        if (st_q.ctrl.cont_swap)
            st_d.ctrl.bank = ~st_q.ctrl.bank;
        if (hit_coef)
            st_d.bank[~st_q.ctrl.bank][wr_addr] = wr_data;
        if (hit_ctrl)
            st_d.ctrl = ctrl_t'(wr_data[CTRL_BITS-1:0]);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign coef_o        = st_q.bank[st_q.ctrl.bank];
    assign data_signed_o = st_q.ctrl.data_signed;
    assign coef_signed_o = st_q.ctrl.coef_signed;

    // R4: loading the shadow bank leaves the active coefficients untouched
    assert_shadow_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!(wr_en && wr_addr == CTRL_ADDR) && !st_q.ctrl.cont_swap) |=> $stable(coef_o));

    // R5: control word is in force one edge after it is written
    assert_ctrl_apply_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == CTRL_ADDR) |=>
        (st_q.ctrl == $past(ctrl_t'(wr_data[CTRL_BITS-1:0]))));

    // R6: continuous swap flips the bank each edge unless overridden
    assert_cont_flip_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ctrl.cont_swap && !(wr_en && wr_addr == CTRL_ADDR)) |=>
        (st_q.ctrl.bank != $past(st_q.ctrl.bank)));

    // R10: the hole in the address map is inert
    assert_hole_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && int'(wr_addr) >= NTAP && wr_addr != CTRL_ADDR && !st_q.ctrl.cont_swap)
        |=> $stable(st_q));

endmodule

// File: rtl/mac_section.sv
module mac_section #(
    parameter int DATA_W = 8,
    parameter int COEF_W = 8,
    parameter int STAGES = 7,
    parameter int ACC_W  = 22
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DATA_W-1:0]        x_i,
    input  logic [STAGES*COEF_W-1:0] coef_i,
    input  logic                     data_signed_i,
    input  logic                     coef_signed_i,
    input  logic [ACC_W-1:0]         chain_i,
    output logic [ACC_W-1:0]         sum_o
);

    localparam int PROD_W = DATA_W + COEF_W + 2;

    typedef struct packed {
        logic [STAGES-1:0][ACC_W-1:0] acc;
    } sec_t;

    sec_t sec_d, sec_q;
    logic signed [DATA_W:0] x_ext;

    assign x_ext = {data_signed_i & x_i[DATA_W-1], x_i};

    always_comb begin
        logic signed [COEF_W:0]   c_ext;
        logic signed [PROD_W-1:0] prod;
        logic [ACC_W-1:0]         carry;
        sec_d = sec_q;
        carry = chain_i;
        for (int j = 0; j < STAGES; j++) begin
            c_ext = {coef_signed_i & coef_i[j*COEF_W+COEF_W-1], coef_i[j*COEF_W +: COEF_W]};
            prod  = x_ext * c_ext;
            sec_d.acc[j] = carry + {{(ACC_W-PROD_W){prod[PROD_W-1]}}, prod};
            carry = sec_q.acc[j];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sec_q <= '0;
        else        sec_q <= sec_d;
    end

    assign sum_o = sec_q.acc[STAGES-1];

    // R2: all-zero coefficients and a zero chain input empty the first stage next edge
    assert_zero_stage_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (coef_i[COEF_W-1:0] == '0 && chain_i == '0) |=> (sec_q.acc[0] == '0));

endmodule

// File: rtl/dual_bank_mac_array.sv
module dual_bank_mac_array #(
    parameter int DATA_W   = 8,
    parameter int COEF_W   = 8,
    parameter int SECTIONS = 3,
    parameter int STAGES   = 7,
    parameter int ACC_W    = 22,
    parameter int ADDR_W   = 5
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [SECTIONS*DATA_W-1:0] taps_i,
    input  logic                       wr_en_i,
    input  logic [ADDR_W-1:0]          wr_addr_i,
    input  logic [COEF_W-1:0]          wr_data_i,
    output logic [ACC_W-1:0]           sum_o
);

    localparam int NTAP    = SECTIONS * STAGES;
    localparam int SEC_CW  = STAGES * COEF_W;

    typedef struct packed {
        logic [SECTIONS-2:0][ACC_W-1:0] dly;
    } link_t;

    link_t            link_d, link_q;
    logic [NTAP*COEF_W-1:0] coef_all;
    logic             data_signed, coef_signed;
    logic [ACC_W-1:0] sec_sum [SECTIONS];

    mac_coef_store #(
        .NTAP   (NTAP),
        .COEF_W (COEF_W),
        .ADDR_W (ADDR_W)
    ) u_store (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en_i),
        .wr_addr       (wr_addr_i),
        .wr_data       (wr_data_i),
        .coef_o        (coef_all),
        .data_signed_o (data_signed),
        .coef_signed_o (coef_signed)
    );

    for (genvar s = 0; s < SECTIONS; s++) begin : g_sec
        logic [ACC_W-1:0] chain;
        if (s == 0) begin : g_head
            assign chain = '0;
        end else begin : g_link
            assign chain = link_q.dly[s-1];
        end
        mac_section #(
            .DATA_W (DATA_W),
            .COEF_W (COEF_W),
            .STAGES (STAGES),
            .ACC_W  (ACC_W)
        ) u_sec (
            .clk           (clk),
            .rst_n         (rst_n),
            .x_i           (taps_i[s*DATA_W +: DATA_W]),
            .coef_i        (coef_all[s*SEC_CW +: SEC_CW]),
            .data_signed_i (data_signed),
            .coef_signed_i (coef_signed),
            .chain_i       (chain),
            .sum_o         (sec_sum[s])
        );
    end

    always_comb begin
        link_d = link_q;
        for (int s = 0; s < SECTIONS - 1; s++)
            link_d.dly[s] = sec_sum[s];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) link_q <= '0;
        else        link_q <= link_d;
    end

    assign sum_o = sec_sum[SECTIONS-1];

endmodule

// File: tb/tb_dual_bank_mac_array.sv
module tb_dual_bank_mac_array;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [23:0] taps_i;
    logic        wr_en_i;
    logic [4:0]  wr_addr_i;
    logic [7:0]  wr_data_i;
    logic [21:0] sum_o;

    int checks = 0;
    int failures = 0;

    // bench model state
    int bm [2][21];
    int cur, cont, dsg, csg;
    int prod_h [64][21];
    int t = 0;

    always #10 clk = ~clk;

    dual_bank_mac_array dut (
        .clk(clk), .rst_n(rst_n), .taps_i(taps_i), .wr_en_i(wr_en_i),
        .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .sum_o(sum_o)
    );

    function automatic int ext8(input logic [7:0] v, input int sg);
        if (sg != 0 && v[7]) return int'(v) - 256;
        return int'(v);
    endfunction

    task automatic check(input logic [21:0] act, input logic [21:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Called at a negedge: drive, model the coming edge, wait, compare.
    task automatic step(input logic [23:0] tp, input bit we, input logic [4:0] a,
                        input logic [7:0] d, input string tag);
        int e;
        int nxt;
        taps_i = tp; wr_en_i = we; wr_addr_i = a; wr_data_i = d;
        for (int k = 0; k < 21; k++)
            prod_h[t % 64][k] = ext8(tp[(k/7)*8 +: 8], dsg) * ext8(8'(bm[cur][k]), csg);
        e = 0;
        for (int k = 0; k < 21; k++) begin
            int lag;
            lag = (6 - k % 7) + 8 * (2 - k / 7);
            if (t - lag >= 0) e += prod_h[(t - lag) % 64][k];
        end
        nxt = (cont != 0) ? 1 - cur : cur;
        if (we) begin
            if (a < 21) bm[1-cur][a] = int'(d);
            if (a == 31) begin
                nxt = int'(d[0]); cont = int'(d[1]); dsg = int'(d[2]); csg = int'(d[3]);
            end
        end
        cur = nxt;
        t++;
        @(negedge clk);
        check(sum_o, e[21:0], tag);
    endtask

    function automatic logic [23:0] rnd_taps();
        return 24'($urandom);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int b = 0; b < 2; b++) for (int k = 0; k < 21; k++) bm[b][k] = 0;
        for (int r = 0; r < 64; r++) for (int k = 0; k < 21; k++) prod_h[r][k] = 0;
        cur = 0; cont = 0; dsg = 0; csg = 0;
        rst_n = 1'b0; taps_i = '0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0;
        repeat (4) @(negedge clk);
        check(sum_o, 22'd0, "R1 reset output");
        rst_n = 1'b1;

        // R1/R4: load bank 1 while bank 0 (all zero) stays active
        for (int k = 0; k < 21; k++)
            step(rnd_taps(), 1'b1, 5'(k), 8'(3 * k + 1), "R4 shadow load");
        for (int n = 0; n < 25; n++) step(rnd_taps(), 1'b0, 5'd0, 8'd0, "R1 zero bank");

        // R5: manual swap to bank 1, unsigned
        step(rnd_taps(), 1'b1, 5'd31, 8'h01, "R5 manual swap");
        for (int n = 0; n < 30; n++) step(rnd_taps(), 1'b0, 5'd0, 8'd0, "R5 after swap");

        // R2/R3: isolated impulses per section
        for (int s = 0; s < 3; s++) begin
            step(24'(8'd1) << (8 * s), 1'b0, 5'd0, 8'd0, "R3 impulse");
            for (int n = 0; n < 26; n++) step(24'd0, 1'b0, 5'd0, 8'd0, "R2 R3 impulse tail");
        end

        // R7/R8: all four format combinations with random coefficients
        for (int f = 0; f < 4; f++) begin
            for (int k = 0; k < 21; k++)
                step(rnd_taps(), 1'b1, 5'(k), 8'($urandom), "R4 reload");
            step(rnd_taps(), 1'b1, 5'd31, 8'((f << 2) | (1 - cur)), "R7 R8 format switch");
            for (int n = 0; n < 40; n++) step(rnd_taps(), 1'b0, 5'd0, 8'd0, "R7 R8 random data");
        end

        // R9: extreme magnitudes, unsigned then signed
        for (int k = 0; k < 21; k++) step(24'hFFFFFF, 1'b1, 5'(k), 8'hFF, "R9 load max");
        step(24'hFFFFFF, 1'b1, 5'd31, 8'(1 - cur), "R9 swap unsigned");
        for (int n = 0; n < 26; n++) step(24'hFFFFFF, 1'b0, 5'd0, 8'd0, "R9 unsigned max");
        check(sum_o, 22'd1365525, "R9 unsigned peak");
        for (int k = 0; k < 21; k++) step(24'h808080, 1'b1, 5'(k), 8'h80, "R9 load min");
        step(24'h808080, 1'b1, 5'd31, 8'(8'h0C | 8'(1 - cur)), "R9 swap signed");
        for (int n = 0; n < 26; n++) step(24'h808080, 1'b0, 5'd0, 8'd0, "R9 signed min");
        check(sum_o, 22'd344064, "R9 signed peak");

        // R10: hole addresses are inert
        for (int a = 21; a < 31; a++) step(rnd_taps(), 1'b1, 5'(a), 8'($urandom), "R10 hole write");
        for (int n = 0; n < 25; n++) step(rnd_taps(), 1'b0, 5'd0, 8'd0, "R10 after holes");

        // R6: continuous swap with coefficient writes every cycle
        step(rnd_taps(), 1'b1, 5'd31, 8'h06, "R6 enable continuous");
        for (int n = 0; n < 63; n++)
            step(rnd_taps(), 1'b1, 5'(n % 21), 8'($urandom), "R6 write during swap");
        // control writes colliding with the pending inversion
        for (int n = 0; n < 8; n++) begin
            step(rnd_taps(), 1'b1, 5'd31, 8'(8'h06 | 8'(n % 2 == 0 ? cur : 1 - cur)), "R6 override");
            step(rnd_taps(), 1'b0, 5'd0, 8'd0, "R6 after override");
        end
        step(rnd_taps(), 1'b1, 5'd31, 8'h0C, "R6 disable continuous");
        for (int n = 0; n < 30; n++) step(rnd_taps(), 1'b0, 5'd0, 8'd0, "R6 R8 settle");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule